// File: doc/BRIEF.md
# Machine-Level Double-Trap Controller

This block holds the machine-level trap-disable flag and the machine interrupt enable. It judges every trap request aimed at machine mode. While the disable flag is clear, a trap is delivered normally and the flag is set, so a second trap that arrives before the handler has saved its state is caught. That second trap is the unexpected trap. It is escalated in one of two ways:

- It is redirected to the resumable NMI handler, together with the cause and return address that the NMI registers must load.
- If that handler is unavailable, the block enters a critical-error state. The state halts the hart, masks every interrupt source and raises a critical-error flag. No architectural state is updated.

The status write port follows the rules that tie the disable flag to the interrupt enable. A parameter selects either the 64-bit status layout or a split 32-bit layout with a separate high status word. An MRET strobe clears the disable flag.

Trap requests use a valid/ready handshake. `trap_ready` is high in every cycle except in the critical-error state. A requester holds `trap_valid`, cause, return address and origin stable until the handshake completes. The verdict is a one-cycle pulse with no back-pressure, issued the cycle after acceptance.

Top module: `mdt_guard`

## Requirements
- R1: After reset the disable flag `mdt` is 1, `mie` is 0, `crit_err` is 0, `trap_ready` is 1 and `vd_valid` is 0.
- R2: In the 64-bit layout, a status write with `csr_hi`=0 loads `mdt` from data bit 42. When that bit is 1, `mie` becomes 0 whatever data bit 3 holds.
- R3: A status write sets `mie` to 1 (from data bit 3) only if `mdt` is already 0, or the same write clears `mdt`.
- R4: When an accepted trap is judged expected, the next cycle carries `vd_valid`=1 and `vd_kind`=0, with the request's cause and return address on `vd_cause`/`vd_epc`. `mdt` becomes 1. The verdict lasts one cycle.
- R5: A trap is unexpected when `mdt` is 1. With the NMI option present, a trap whose origin is machine mode (`trap_from_m`=1) while `nmie_i` is 0 is also unexpected.
- R6: An unexpected trap with the NMI option present and `nmie_i`=1 yields `vd_kind`=1, the cause and return address, `vd_priv`=3 (machine) and a one-cycle `nmie_clr` pulse. `mdt` and `mie` keep their values.
- R7: Every other unexpected trap yields `vd_kind`=2 and sets `crit_err`. `mdt` and `mie` keep their values.
- R8: The critical-error state lasts until reset. While it holds: `crit_err` is 1; `trap_ready`, `irq_allow` and `nmi_allow` are 0; trap requests, status writes and MRET strobes are ignored.
- R9: An MRET strobe clears `mdt` to 0.
- R10: A trap accepted in the same cycle as an MRET strobe or a status write takes priority. The strobe or write is dropped.
- R11: In the 32-bit layout, `mdt` sits at bit 10 of the high word (`csr_hi`=1), and the two halves follow separate rules. A high write that sets `mdt` clears `mie`. A low write sets `mie` from bit 3 only while `mdt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Status write strobe |
| csr_hi | input | 1 | Selects the high status word (32-bit layout) |
| csr_wdata | input | XLEN | Status write data |
| mret | input | 1 | MRET retirement strobe |
| trap_valid | input | 1 | Trap request valid |
| trap_ready | output | 1 | Trap request accepted this cycle when valid |
| trap_cause | input | CAUSE_W | Cause code of the trap |
| trap_epc | input | XLEN | Return address of the trap |
| trap_from_m | input | 1 | Trap raised while executing in machine mode |
| nmie_i | input | 1 | Resumable-NMI enable state |
| mdt | output | 1 | Machine trap-disable flag |
| mie | output | 1 | Machine interrupt enable |
| vd_valid | output | 1 | Verdict pulse |
| vd_kind | output | 2 | 0 deliver, 1 NMI redirect, 2 critical error |
| vd_cause | output | CAUSE_W | Cause to load into the handler's cause register |
| vd_epc | output | XLEN | Return address to load into the handler's EPC register |
| vd_priv | output | 2 | Previous-privilege value for the NMI status (3 on redirect) |
| nmie_clr | output | 1 | Pulse that clears the NMI enable |
| crit_err | output | 1 | Critical-error flag to the platform |
| irq_allow | output | 1 | Ordinary interrupts may be taken |
| nmi_allow | output | 1 | NMIs may be taken |

## Verification
Trap acceptance can fall in the same cycle as an MRET strobe or a status write, and both sides change `mdt`.

- **Trap with MRET.** The bench sets `mdt` to 1 and `nmie_i` to 1, then raises the trap and MRET at one edge. The NMI redirect must leave `mdt` at 1, while MRET alone would clear it.
- **Trap with status write.** The bench pairs a write that would set `mie` with an expected trap. `mie` must still read 0 afterwards, and the deliver verdict must appear.

// File: rtl/mdt_guard_pkg.sv
package mdt_guard_pkg;
  typedef enum logic [1:0] {
    VD_DELIVER = 2'd0,
    VD_NMI     = 2'd1,
    VD_CRIT    = 2'd2
  } verdict_e;

  localparam int MIE_BIT      = 3;
  localparam int MDT_BIT_WIDE = 42;
  localparam int MDT_BIT_HI   = 10;
  localparam logic [1:0] PRIV_M = 2'b11;
endpackage

// File: rtl/mdt_csr_ctl.sv
module mdt_csr_ctl
  import mdt_guard_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_hi,
  input  logic [XLEN-1:0] wdata,
  input  logic            trap_set,
  input  logic            mret_clr,
  output logic            mdt_q,
  output logic            mie_q
);
  localparam bit SPLIT   = (XLEN == 32);
  localparam int MDT_POS = SPLIT ? MDT_BIT_HI : MDT_BIT_WIDE;

  logic mdt_d, mie_d;

  always_comb begin
    mdt_d = mdt_q;
    mie_d = mie_q;
    if (trap_set) begin
      mdt_d = 1'b1;
    end else if (mret_clr) begin
      mdt_d = 1'b0;
    end else if (wr_en) begin
      if (SPLIT) begin
        if (wr_hi) begin
          mdt_d = wdata[MDT_POS];
          if (wdata[MDT_POS]) mie_d = 1'b0;
        end else begin
          mie_d = wdata[MIE_BIT] & ~mdt_q;
        end
      end else if (!wr_hi) begin
        mdt_d = wdata[MDT_POS];
        mie_d = wdata[MIE_BIT] & ~wdata[MDT_POS];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdt_q <= 1'b1;
      mie_q <= 1'b0;
    end else begin
      mdt_q <= mdt_d;
      mie_q <= mie_d;
    end
  end

  // R1: reset value of the flags
  a_r1_reset_flags: assert property (@(posedge clk) !rst_n |=> (mdt_q && !mie_q));

  // R2 / R11: a write that sets the disable flag leaves the enable low
  a_r2_set_clears_mie: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_hi == SPLIT) && wdata[MDT_POS] && !trap_set && !mret_clr)
      |=> (mdt_q && !mie_q));

  // R3: the enable can only rise while the disable flag is clear
  a_r3_mie_rise_guard: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mie_q) |-> !mdt_q);

  // R9: MRET clears the disable flag
  a_r9_mret_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_clr && !trap_set) |=> !mdt_q);
endmodule

// File: rtl/mdt_trap_judge.sv
module mdt_trap_judge
  import mdt_guard_pkg::*;
#(
  parameter bit HAS_NMI = 1'b1
) (
  input  logic     mdt,
  input  logic     from_m,
  input  logic     nmie,
  output verdict_e kind
);
  logic nmi_lock;
  logic unexpected;

  always_comb begin
    nmi_lock   = HAS_NMI && from_m && !nmie;
    unexpected = mdt || nmi_lock;
    if (!unexpected)          kind = VD_DELIVER;
    else if (HAS_NMI && nmie) kind = VD_NMI;
    else                      kind = VD_CRIT;
  end
endmodule

// File: rtl/mdt_verdict_reg.sv
module mdt_verdict_reg
  import mdt_guard_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  verdict_e           kind,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [XLEN-1:0]    epc,
  output logic               vd_valid,
  output verdict_e           vd_kind,
  output logic [CAUSE_W-1:0] vd_cause,
  output logic [XLEN-1:0]    vd_epc,
  output logic [1:0]         vd_priv,
  output logic               nmie_clr,
  output logic               crit_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd_valid <= 1'b0;
      vd_kind  <= VD_DELIVER;
      vd_cause <= '0;
      vd_epc   <= '0;
      vd_priv  <= 2'b00;
      nmie_clr <= 1'b0;
      crit_q   <= 1'b0;
    end else begin
      vd_valid <= fire;
      nmie_clr <= fire && (kind == VD_NMI);
      if (fire) begin
        vd_kind  <= kind;
        vd_cause <= cause;
        vd_epc   <= epc;
        vd_priv  <= (kind == VD_NMI) ? PRIV_M : 2'b00;
        if (kind == VD_CRIT) crit_q <= 1'b1;
      end
    end
  end

  // R8: the critical-error state holds until reset
  a_r8_crit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    crit_q |=> crit_q);

  // R7: a critical verdict comes with the flag raised
  a_r7_crit_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && vd_kind == VD_CRIT) |-> crit_q);
endmodule

// File: rtl/mdt_guard.sv
module mdt_guard
  import mdt_guard_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 6,
  parameter bit HAS_NMI = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_we,
  input  logic               csr_hi,
  input  logic [XLEN-1:0]    csr_wdata,
  input  logic               mret,
  input  logic               trap_valid,
  output logic               trap_ready,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_epc,
  input  logic               trap_from_m,
  input  logic               nmie_i,
  output logic               mdt,
  output logic               mie,
  output logic               vd_valid,
  output logic [1:0]         vd_kind,
  output logic [CAUSE_W-1:0] vd_cause,
  output logic [XLEN-1:0]    vd_epc,
  output logic [1:0]         vd_priv,
  output logic               nmie_clr,
  output logic               crit_err,
  output logic               irq_allow,
  output logic               nmi_allow
);
  verdict_e kind, vd_kind_e;
  logic     crit_q, fire, trap_set, mret_eff, wr_eff;

  assign trap_ready = ~crit_q;
  assign fire       = trap_valid & trap_ready;
  assign trap_set   = fire & (kind == VD_DELIVER);
  assign mret_eff   = mret & ~fire & ~crit_q;
  assign wr_eff     = csr_we & ~fire & ~crit_q & ~mret;

  mdt_trap_judge #(.HAS_NMI(HAS_NMI)) u_judge (
    .mdt    (mdt),
    .from_m (trap_from_m),
    .nmie   (nmie_i),
    .kind   (kind)
  );

  mdt_csr_ctl #(.XLEN(XLEN)) u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_eff),
    .wr_hi    (csr_hi),
    .wdata    (csr_wdata),
    .trap_set (trap_set),
    .mret_clr (mret_eff),
    .mdt_q    (mdt),
    .mie_q    (mie)
  );

  mdt_verdict_reg #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_verdict (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .kind     (kind),
    .cause    (trap_cause),
    .epc      (trap_epc),
    .vd_valid (vd_valid),
    .vd_kind  (vd_kind_e),
    .vd_cause (vd_cause),
    .vd_epc   (vd_epc),
    .vd_priv  (vd_priv),
    .nmie_clr (nmie_clr),
    .crit_q   (crit_q)
  );

  assign vd_kind   = vd_kind_e;
  assign crit_err  = crit_q;
  assign irq_allow = mie & ~crit_q;
  assign nmi_allow = HAS_NMI && nmie_i && !crit_q;

  // R4: an expected trap sets the disable flag
  a_r4_deliver_sets_mdt: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == VD_DELIVER) |=> (mdt && vd_valid));

  // R6 / R7: escalated traps leave the status flags alone
  a_r7_escalate_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind != VD_DELIVER) |=> ($stable(mdt) && $stable(mie)));

  // R8: nothing changes and nothing is accepted in the critical state
  a_r8_crit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    crit_err |=> ($stable(mdt) && $stable(mie) && !trap_ready && !irq_allow));

  // R10: a trap beside an MRET leaves the flag set unless it halts
  a_r10_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mret && kind != VD_CRIT) |=> mdt);
endmodule

// File: tb/mdt_guard_bench.sv
module mdt_guard_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        csr_we, csr_hi, mret, trap_valid, trap_from_m, nmie_i;
  logic [63:0] csr_wdata, trap_epc;
  logic [5:0]  trap_cause;
  wire         trap_ready, mdt, mie, vd_valid, nmie_clr, crit_err, irq_allow, nmi_allow;
  wire [1:0]   vd_kind, vd_priv;
  wire [5:0]   vd_cause;
  wire [63:0]  vd_epc;

  logic        h_we, h_hi;
  logic [31:0] h_wdata;
  wire         h_ready, h_mdt, h_mie, h_vd_valid, h_nmie_clr, h_crit, h_irq, h_nmi;
  wire [1:0]   h_vd_kind, h_vd_priv;
  wire [5:0]   h_vd_cause;
  wire [31:0]  h_vd_epc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  mdt_guard u_mdt_guard (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_hi(csr_hi), .csr_wdata(csr_wdata),
    .mret(mret), .trap_valid(trap_valid), .trap_ready(trap_ready), .trap_cause(trap_cause),
    .trap_epc(trap_epc), .trap_from_m(trap_from_m), .nmie_i(nmie_i), .mdt(mdt), .mie(mie),
    .vd_valid(vd_valid), .vd_kind(vd_kind), .vd_cause(vd_cause), .vd_epc(vd_epc),
    .vd_priv(vd_priv), .nmie_clr(nmie_clr), .crit_err(crit_err), .irq_allow(irq_allow),
    .nmi_allow(nmi_allow)
  );

  mdt_guard #(.XLEN(32)) u_mdt_guard_h32 (
    .clk(clk), .rst_n(rst_n), .csr_we(h_we), .csr_hi(h_hi), .csr_wdata(h_wdata),
    .mret(1'b0), .trap_valid(1'b0), .trap_ready(h_ready), .trap_cause(6'd0),
    .trap_epc(32'd0), .trap_from_m(1'b0), .nmie_i(1'b0), .mdt(h_mdt), .mie(h_mie),
    .vd_valid(h_vd_valid), .vd_kind(h_vd_kind), .vd_cause(h_vd_cause), .vd_epc(h_vd_epc),
    .vd_priv(h_vd_priv), .nmie_clr(h_nmie_clr), .crit_err(h_crit), .irq_allow(h_irq),
    .nmi_allow(h_nmi)
  );

  localparam logic [63:0] B_MIE = 64'h8;
  localparam logic [63:0] B_MDT = 64'h1 << 42;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    csr_we = 0; csr_hi = 0; csr_wdata = '0; mret = 0;
    trap_valid = 0; trap_cause = '0; trap_epc = '0; trap_from_m = 0; nmie_i = 0;
    h_we = 0; h_hi = 0; h_wdata = '0;
  endtask

  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [63:0] d);
    csr_we = 1; csr_wdata = d; step();
  endtask

  task automatic t_reset();
    chk("R1 mdt", mdt, 1); chk("R1 mie", mie, 0); chk("R1 crit", crit_err, 0);
    chk("R1 ready", trap_ready, 1); chk("R1 vd_valid", vd_valid, 0);
  endtask

  task automatic t_write64();
    wr(B_MDT | B_MIE);
    chk("R2 mdt set", mdt, 1); chk("R2 mie forced 0", mie, 0);
    wr(B_MIE);
    chk("R3 mdt cleared", mdt, 0); chk("R3 mie set with clear", mie, 1);
    wr(B_MDT | B_MIE);
    chk("R2 mdt reset by write", mdt, 1); chk("R2 mie cleared", mie, 0);
  endtask

  task automatic t_mret();
    mret = 1; step();
    chk("R9 mret clears", mdt, 0);
  endtask

  task automatic t_normal();
    trap_valid = 1; trap_cause = 6'd5; trap_epc = 64'h1000; nmie_i = 1; step();
    chk("R4 valid", vd_valid, 1); chk("R4 kind", vd_kind, 0);
    chk("R4 cause", vd_cause, 5); chk("R4 epc", vd_epc, 64'h1000);
    chk("R4 mdt set", mdt, 1);
    step();
    chk("R4 one-cycle pulse", vd_valid, 0);
  endtask

  task automatic t_nmi();
    trap_valid = 1; trap_cause = 6'd7; trap_epc = 64'h2000; nmie_i = 1; step();
    chk("R5 R6 kind", vd_kind, 1); chk("R6 cause", vd_cause, 7);
    chk("R6 epc", vd_epc, 64'h2000); chk("R6 priv", vd_priv, 3);
    chk("R6 nmie_clr", nmie_clr, 1); chk("R6 mdt kept", mdt, 1); chk("R6 crit", crit_err, 0);
    step();
    chk("R6 nmie_clr pulse", nmie_clr, 0);
  endtask

  task automatic t_collide();
    trap_valid = 1; nmie_i = 1; trap_cause = 6'd2; mret = 1; step();
    chk("R10 verdict nmi", vd_kind, 1); chk("R10 mdt not cleared", mdt, 1);
    mret = 1; step();
    chk("R9 mdt clear again", mdt, 0);
    trap_valid = 1; nmie_i = 1; csr_we = 1; csr_wdata = B_MIE; step();
    chk("R10 deliver", vd_kind, 0); chk("R10 write dropped", mie, 0);
    chk("R10 mdt", mdt, 1);
  endtask

  task automatic t_crit_from_m();
    mret = 1; step();
    wr(B_MIE);
    chk("R3 mie on", mie, 1);
    trap_valid = 1; trap_from_m = 1; nmie_i = 0; trap_cause = 6'd9; step();
    chk("R5 R7 kind", vd_kind, 2); chk("R7 crit", crit_err, 1);
    chk("R7 mdt kept", mdt, 0); chk("R7 mie kept", mie, 1);
    nmie_i = 1; trap_valid = 1; csr_we = 1; csr_wdata = B_MDT; #1;
    chk("R8 ready low", trap_ready, 0); chk("R8 irq masked", irq_allow, 0);
    chk("R8 nmi masked", nmi_allow, 0);
    step();
    chk("R8 no verdict", vd_valid, 0); chk("R8 write ignored", mdt, 0);
    mret = 1; step(); step(); step();
    chk("R8 mie kept", mie, 1); chk("R8 sticky", crit_err, 1);
  endtask

  task automatic t_crit_mdt();
    do_reset();
    t_reset();
    trap_valid = 1; nmie_i = 0; trap_from_m = 0; step();
    chk("R5 mdt path crit", vd_kind, 2); chk("R7 crit", crit_err, 1);
    chk("R7 mdt kept", mdt, 1);
  endtask

  task automatic t_split32();
    do_reset();
    chk("R11 reset mdt", h_mdt, 1);
    h_we = 1; h_wdata = 32'h8; step();
    chk("R11 low write blocked", h_mie, 0);
    h_we = 1; h_hi = 1; h_wdata = 32'h0; step();
    chk("R11 high clears mdt", h_mdt, 0);
    h_we = 1; h_wdata = 32'h8; step();
    chk("R11 low sets mie", h_mie, 1);
    h_we = 1; h_hi = 1; h_wdata = 32'h400; step();
    chk("R11 high sets mdt", h_mdt, 1); chk("R11 mie cleared", h_mie, 0);
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    do_reset();
    t_reset();
    t_write64();
    t_mret();
    t_normal();
    t_nmi();
    t_collide();
    t_crit_from_m();
    t_crit_mdt();
    t_split32();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule